// File: doc/BRIEF.md
# Supply Voltage Detector Sampling Controller

This block holds the digital control and status for an on-chip supply-voltage detector. Software reaches it through one 8-bit register on a simple CPU bus. The register has three parts: a periodic-sampling enable, a continuous-sampling switch that reads back as a busy flag, and the 4-bit level of the last result. The analog comparator is outside the block. The block raises `smp_en_o` toward it and takes back a level code with a one-cycle `done_i` strobe.

Sampling runs in one of two ways:

- **Periodic sampling:** a slow tick from a prescaler (one pulse every four seconds) starts one measurement whenever the enable bit is set and no measurement is running.
- **Continuous sampling:** writing the switch bit keeps the front end powered and refreshes the level on every result until software clears the bit.

After reset, the hardware starts a first measurement by itself, and busy reads 1 until that result arrives. A sleep input clears the whole register and stops sampling.

The controller has five states:

| State | Meaning |
|---|---|
| `ST_FIRST` | Sample started by hardware after reset |
| `ST_IDLE` | Front end off |
| `ST_AUTO_RUN` | One periodic sample in flight |
| `ST_CONT_WAIT` | Continuous mode, no result yet |
| `ST_CONT_RUN` | Continuous mode, results flowing |

Transitions, in priority order:

- sleep: any state to IDLE.
- Switch written 1: any non-continuous state to CONT_WAIT.
- Switch written 0: CONT_WAIT or CONT_RUN to IDLE.
- Strobe: FIRST to IDLE, AUTO_RUN to IDLE, CONT_WAIT to CONT_RUN.
- Tick with the enable bit set: IDLE to AUTO_RUN.

Top module: `svd_sampler_ctrl`

## Requirements
- R1: The register sits at address `REG_ADDR`. Its bit 6 is the periodic enable (read/write). Its bit 5 is the continuous switch on write and the busy flag on read. Bits 3..0 hold the level code (0 to 15). Bits 7 and 4 read 0. A read at any other address returns 0x00, and a write at any other address has no effect.
- R2: After reset, `smp_en_o` is 1, busy reads 1 and bit 6 reads 0, until the first strobe.
- R3: The first strobe after reset loads `lvl_i` into bits 3..0 and clears busy. Both show on the cycle after the strobe.
- R4: With bit 6 set and no sample running, a tick raises `smp_en_o` and busy on the next cycle.
- R5: The strobe that ends a periodic sample loads the level, clears busy and drops `smp_en_o`, all on the next cycle.
- R6: A tick while a sample is in flight is dropped, and a tick with bit 6 clear starts nothing.
- R7: Writing bit 5 = 1 clears bit 6, raises `smp_en_o` and sets busy. The first strobe then clears busy. `smp_en_o` stays 1, and every later strobe reloads the level.
- R8: Writing bit 5 = 0 in continuous mode drops `smp_en_o` and busy and keeps the level.
- R9: Write data on bits 7, 4 and 3..0 has no effect.
- R10: Sleep clears the register to 0x00 and drops `smp_en_o`. It wins over a write in the same cycle.
- R11: A strobe while `smp_en_o` is 0 leaves the level unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sleep_i | input | 1 | Sleep: clears register, stops sampling |
| bus_cs_i | input | 1 | Bus select |
| bus_we_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Register address |
| bus_wdata_i | input | DATA_W | Write data |
| bus_rdata_o | output | DATA_W | Read data, 0 when not selected for read |
| tick_i | input | 1 | Periodic sample tick (one-cycle pulse) |
| smp_en_o | output | 1 | Comparator front-end enable |
| lvl_i | input | LVL_W | Level code from the comparator |
| done_i | input | 1 | One-cycle result strobe |

## Verification
The bench goes after five corner cases:

- **Reset busy flag.** A design that clears busy at reset, or never starts the first sample, shows 0 in bit 5 straight after reset.
- **Tick arriving mid-sample.** A design that restarts or doubles the sample keeps `smp_en_o` high after the result.
- **Switch written together with the enable bit.** A design that leaves the enable bit set reads back 0x6x instead of 0x2x.
- **Strobe with the front end off.** A design that latches it shows a changed level while idle.
- **Sleep in the same cycle as a write.** A design that lets the write win keeps `smp_en_o` high or reads nonzero after sleep.

// File: rtl/svd_pkg.sv
package svd_pkg;

    typedef enum logic [2:0] {
        ST_FIRST,
        ST_IDLE,
        ST_AUTO_RUN,
        ST_CONT_WAIT,
        ST_CONT_RUN
    } svd_state_e;

    localparam int BIT_AUTO = 6;
    localparam int BIT_CONT = 5;

endpackage

// File: rtl/svd_bus_dec.sv
module svd_bus_dec #(
    parameter int ADDR_W   = 4,
    parameter int DATA_W   = 8,
    parameter logic [ADDR_W-1:0] REG_ADDR = '0
) (
    input  logic              cs,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              wr_hit,
    output logic              rd_hit,
    output logic              wr_auto,
    output logic              wr_cont
);
    import svd_pkg::*;

    logic addr_hit;
    logic wdata_unused;

    assign addr_hit     = (addr == REG_ADDR);
    assign wr_hit       = cs && we && addr_hit;
    assign rd_hit       = cs && !we && addr_hit;
    assign wr_auto      = wdata[BIT_AUTO];
    assign wr_cont      = wdata[BIT_CONT];
    assign wdata_unused = ^{wdata[DATA_W-1], wdata[BIT_CONT-1:0]};

endmodule

// File: rtl/svd_ctrl_fsm.sv
module svd_ctrl_fsm (
    input  logic clk,
    input  logic rst_n,
    input  logic sleep,
    input  logic wr_hit,
    input  logic wr_cont,
    input  logic auto_en,
    input  logic tick,
    input  logic done,
    output logic busy,
    output logic smp_en,
    output logic cont_start
);
    import svd_pkg::*;

    svd_state_e st_q, st_d;
    logic       in_cont;

    assign in_cont = (st_q == ST_CONT_WAIT) || (st_q == ST_CONT_RUN);

    always_comb begin
        st_d = st_q;
        if (sleep) begin
            st_d = ST_IDLE;
        end else if (wr_hit && wr_cont && !in_cont) begin
            st_d = ST_CONT_WAIT;
        end else if (wr_hit && !wr_cont && in_cont) begin
            st_d = ST_IDLE;
        end else begin
            unique case (st_q)
                ST_FIRST:     if (done) st_d = ST_IDLE;
                ST_IDLE:      if (tick && auto_en) st_d = ST_AUTO_RUN;
                ST_AUTO_RUN:  if (done) st_d = ST_IDLE;
                ST_CONT_WAIT: if (done) st_d = ST_CONT_RUN;
                ST_CONT_RUN:  st_d = ST_CONT_RUN;
                default:      st_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_FIRST;
        else        st_q <= st_d;
    end

    always_comb begin
        busy   = 1'b0;
        smp_en = 1'b0;
        unique case (st_q)
            ST_FIRST:     begin busy = 1'b1; smp_en = 1'b1; end
            ST_IDLE:      begin busy = 1'b0; smp_en = 1'b0; end
            ST_AUTO_RUN:  begin busy = 1'b1; smp_en = 1'b1; end
            ST_CONT_WAIT: begin busy = 1'b1; smp_en = 1'b1; end
            ST_CONT_RUN:  begin busy = 1'b0; smp_en = 1'b1; end
            default:      begin busy = 1'b0; smp_en = 1'b0; end
        endcase
    end

    assign cont_start = !sleep && wr_hit && wr_cont;

endmodule

// File: rtl/svd_hold_regs.sv
module svd_hold_regs #(
    parameter int LVL_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sleep,
    input  logic             wr_hit,
    input  logic             wr_auto,
    input  logic             cont_start,
    input  logic             capture,
    input  logic [LVL_W-1:0] lvl_in,
    output logic             auto_en,
    output logic [LVL_W-1:0] lvl_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          auto_en <= 1'b0;
        else if (sleep)      auto_en <= 1'b0;
        else if (cont_start) auto_en <= 1'b0;
        else if (wr_hit)     auto_en <= wr_auto;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lvl_q <= '0;
        else if (sleep)   lvl_q <= '0;
        else if (capture) lvl_q <= lvl_in;
    end

endmodule

// File: rtl/svd_sampler_ctrl.sv
module svd_sampler_ctrl #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int LVL_W  = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sleep_i,
    input  logic              bus_cs_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [DATA_W-1:0] bus_wdata_i,
    output logic [DATA_W-1:0] bus_rdata_o,
    input  logic              tick_i,
    output logic              smp_en_o,
    input  logic [LVL_W-1:0]  lvl_i,
    input  logic              done_i
);
    import svd_pkg::*;

    logic             wr_hit, rd_hit, wr_auto, wr_cont;
    logic             busy, smp_en, cont_start, capture;
    logic             auto_en_q;
    logic [LVL_W-1:0] lvl_q;

    svd_bus_dec #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .REG_ADDR(REG_ADDR)
    ) u_dec (
        .cs(bus_cs_i), .we(bus_we_i), .addr(bus_addr_i), .wdata(bus_wdata_i),
        .wr_hit(wr_hit), .rd_hit(rd_hit), .wr_auto(wr_auto), .wr_cont(wr_cont)
    );

    svd_ctrl_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .sleep(sleep_i),
        .wr_hit(wr_hit), .wr_cont(wr_cont), .auto_en(auto_en_q),
        .tick(tick_i), .done(done_i),
        .busy(busy), .smp_en(smp_en), .cont_start(cont_start)
    );

    assign capture = done_i && smp_en && !sleep_i;

    svd_hold_regs #(.LVL_W(LVL_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .sleep(sleep_i),
        .wr_hit(wr_hit), .wr_auto(wr_auto), .cont_start(cont_start),
        .capture(capture), .lvl_in(lvl_i),
        .auto_en(auto_en_q), .lvl_q(lvl_q)
    );

    assign smp_en_o = smp_en;

    always_comb begin
        bus_rdata_o = '0;
        if (rd_hit) begin
            bus_rdata_o[BIT_AUTO]  = auto_en_q;
            bus_rdata_o[BIT_CONT]  = busy;
            bus_rdata_o[LVL_W-1:0] = lvl_q;
        end
    end

endmodule

// File: rtl/svd_sampler_chk.sv
module svd_sampler_chk #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8,
    parameter int LVL_W  = 4,
    parameter logic [ADDR_W-1:0] REG_ADDR = 4'h2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sleep_i,
    input logic              bus_cs_i,
    input logic              bus_we_i,
    input logic [ADDR_W-1:0] bus_addr_i,
    input logic [DATA_W-1:0] bus_wdata_i,
    input logic              tick_i,
    input logic              done_i,
    input logic [LVL_W-1:0]  lvl_i,
    input logic              smp_en_o,
    input logic              auto_en_q,
    input logic              busy,
    input logic [LVL_W-1:0]  lvl_q
);
    import svd_pkg::*;

    logic first_pend;
    logic wr_sw_on;

    assign wr_sw_on = bus_cs_i && bus_we_i && (bus_addr_i == REG_ADDR)
                      && bus_wdata_i[BIT_CONT];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                            first_pend <= 1'b1;
        else if (sleep_i || (done_i && smp_en_o)) first_pend <= 1'b0;
    end

    // R2
    first_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        first_pend |-> (busy && smp_en_o));

    // R3
    level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && smp_en_o && !sleep_i) |=> (lvl_q == $past(lvl_i)));

    // R11
    level_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!(done_i && smp_en_o) && !sleep_i) |=> $stable(lvl_q));

    // R4
    tick_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_i && auto_en_q && !smp_en_o && !sleep_i && !wr_sw_on)
        |=> (busy && smp_en_o));

    // R7
    cont_cancel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_sw_on && !sleep_i) |=> (!auto_en_q && smp_en_o));

    // R10
    sleep_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_i |=> (!smp_en_o && !auto_en_q && !busy && lvl_q == '0));

    // R7
    busy_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> smp_en_o);

endmodule

bind svd_sampler_ctrl svd_sampler_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LVL_W(LVL_W), .REG_ADDR(REG_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
    .bus_cs_i(bus_cs_i), .bus_we_i(bus_we_i), .bus_addr_i(bus_addr_i),
    .bus_wdata_i(bus_wdata_i), .tick_i(tick_i), .done_i(done_i), .lvl_i(lvl_i),
    .smp_en_o(smp_en_o), .auto_en_q(auto_en_q), .busy(busy), .lvl_q(lvl_q)
);

// File: tb/svd_sampler_ctrl_tb.sv
`timescale 1ns/1ps
module svd_sampler_ctrl_tb;

    localparam int DLY = 5;
    localparam logic [3:0] REG = 4'h2;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       sleep_i = 0;
    logic       cs = 0, we = 0;
    logic [3:0] addr = REG;
    logic [7:0] wdata = 0;
    logic [7:0] rdata;
    logic       tick = 0;
    logic       smp_en;
    logic [3:0] mdl_lvl = 0;
    logic       mdl_done = 0, frc_done = 0, done_i;
    int         cnt = 0;
    int         n_run = 0, n_fail = 0;

    always #5 clk = ~clk;

    assign done_i = mdl_done | frc_done;

    svd_sampler_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .sleep_i(sleep_i),
        .bus_cs_i(cs), .bus_we_i(we), .bus_addr_i(addr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata),
        .tick_i(tick), .smp_en_o(smp_en), .lvl_i(mdl_lvl), .done_i(done_i)
    );

    // comparator model: strobe every DLY cycles while enabled
    always @(posedge clk) begin
        if (!rst_n || !smp_en) begin
            cnt <= 0; mdl_done <= 0;
        end else if (cnt == DLY-1) begin
            cnt <= 0; mdl_done <= 1;
        end else begin
            cnt <= cnt + 1; mdl_done <= 0;
        end
    end

    task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        cs = 1; we = 0; addr = a;
        #1 d = rdata;
        cs = 0; addr = REG;
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1; we = 1; addr = a; wdata = d;
        @(negedge clk);
        cs = 0; we = 0; addr = REG; wdata = 0;
    endtask

    task automatic pulse_tick();
        @(negedge clk); tick = 1;
        @(negedge clk); tick = 0;
    endtask

    task automatic wait_done(string req);
        bit seen = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (done_i) begin seen = 1; break; end
        end
        if (!seen) begin
            n_run++; n_fail++;
            $display("FAIL %s: got no strobe expected strobe", req);
        end
        @(negedge clk);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 0;
        repeat (3) @(negedge clk);
        rst_n = 1;
        rd(REG, d);
        chk("R2 reset upper bits", {d[7:4], 4'h0}, 8'h20);
        chk("R2 reset smp_en", {7'h0, smp_en}, 8'h01);
    endtask

    task automatic t_first();
        logic [7:0] d;
        mdl_lvl = 4'h9;
        wait_done("R3");
        rd(REG, d);
        chk("R3 first result", d, 8'h09);
        chk("R3 smp_en off", {7'h0, smp_en}, 8'h00);
    endtask

    task automatic t_idle_ignore();
        logic [7:0] d;
        @(negedge clk); mdl_lvl = 4'h3; frc_done = 1;
        @(negedge clk); frc_done = 0;
        rd(REG, d);
        chk("R11 stray strobe", d, 8'h09);
        pulse_tick();
        chk("R6 tick with enable clear", {7'h0, smp_en}, 8'h00);
        wr(REG, 8'h9F);
        rd(REG, d);
        chk("R9 ignored bits", d, 8'h09);
    endtask

    task automatic t_auto();
        logic [7:0] d;
        wr(REG, 8'h40);
        rd(REG, d);
        chk("R1 enable readback", d, 8'h49);
        pulse_tick();
        rd(REG, d);
        chk("R4 tick starts sample", d, 8'h69);
        chk("R4 smp_en", {7'h0, smp_en}, 8'h01);
        mdl_lvl = 4'hC;
        pulse_tick();
        wait_done("R5");
        rd(REG, d);
        chk("R5 periodic result", d, 8'h4C);
        chk("R5 smp_en drops", {7'h0, smp_en}, 8'h00);
        for (int i = 0; i < 3*DLY; i++) begin
            @(negedge clk);
            if (smp_en) begin
                n_run++; n_fail++;
                $display("FAIL R6 dropped tick: got smp_en 1 expected 0");
                break;
            end
        end
    endtask

    task automatic t_cont();
        logic [7:0] d;
        wr(REG, 8'h60);
        rd(REG, d);
        chk("R7 switch clears enable, busy", d, 8'h2C);
        mdl_lvl = 4'h7;
        wait_done("R7");
        rd(REG, d);
        chk("R7 first continuous result", d, 8'h07);
        chk("R7 smp_en held", {7'h0, smp_en}, 8'h01);
        mdl_lvl = 4'h2;
        wait_done("R7");
        rd(REG, d);
        chk("R7 later result", d, 8'h02);
        wr(REG, 8'h00);
        rd(REG, d);
        chk("R8 switch off", d, 8'h02);
        chk("R8 smp_en off", {7'h0, smp_en}, 8'h00);
    endtask

    task automatic t_sleep();
        logic [7:0] d;
        wr(REG, 8'h40);
        pulse_tick();
        @(negedge clk);
        sleep_i = 1; cs = 1; we = 1; addr = REG; wdata = 8'h20;
        @(negedge clk);
        sleep_i = 0; cs = 0; we = 0; wdata = 0;
        rd(REG, d);
        chk("R10 sleep clears", d, 8'h00);
        chk("R10 smp_en off", {7'h0, smp_en}, 8'h00);
        pulse_tick();
        chk("R10 enable gone", {7'h0, smp_en}, 8'h00);
    endtask

    task automatic t_addr();
        logic [7:0] d;
        wr(REG ^ 4'h1, 8'h60);
        chk("R1 foreign write", {7'h0, smp_en}, 8'h00);
        rd(REG ^ 4'h1, d);
        chk("R1 foreign read", d, 8'h00);
    endtask

    initial begin
        t_reset();
        t_first();
        t_idle_ignore();
        t_auto();
        t_cont();
        t_sleep();
        t_addr();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule